// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing controller of a successive-approximation converter. A start request can come from software or from an event and may arrive with no relation to the input clock. The block brings it into the input-clock domain and then runs one conversion. A conversion is a sampling window, then an optional offset-compensation window, then one decision cycle per result bit. The comparator decision for each bit is taken from the `cmp_in` input, and the finished code is presented on `result` together with a one-cycle `ready` pulse.

All phases are counted in conversion-clock cycles. One conversion-clock cycle is 2^(1+`prescale`) input-clock cycles, so the smallest divide is 2. Prescaler, resolution, sample length and compensation enable are captured when a conversion begins, so a change to them takes effect only from the next conversion. In free-running mode a new conversion follows each result with no gap. Clearing `free_run` lets the conversion in progress finish and then leaves the sequencer idle.

Top module: `adc_seq`

## Requirements
- R1: A rising edge of `start_req` passes a two-flop synchronizer and an edge detector. When the sequencer is idle, `samp_en` goes high on the third rising clock edge after the request rises. A request that stays high does not start a second conversion.
- R2: One conversion-clock cycle lasts 2^(1+`prescale`) input-clock cycles. In the data phase, `bit_stb` pulses once in every such cycle, on its last input-clock cycle.
- R3: With `offcomp`=0, `samp_en` stays high for (`samp_len`+1) conversion-clock cycles, starting at the start of the conversion. `comp_en` stays low.
- R4: With `offcomp`=1, the sampling window is 4 conversion-clock cycles whatever `samp_len` holds. It is followed by 1 conversion-clock cycle with `comp_en` high. `samp_en` and `comp_en` are never high together.
- R5: The data phase gives exactly 12, 10 or 8 `bit_stb` pulses for `res_sel` = 0 (or 3), 1 or 2. `bit_stb` is never high while `samp_en` or `comp_en` is high.
- R6: The bit decided at each `bit_stb` is the value of `cmp_in` in that cycle, with the most significant bit decided first. The code is right-aligned in `result`, and the unused upper bits are zero. `result` changes only in the cycle where `ready` is high. `ready` lasts one input-clock cycle per conversion.
- R7: In free-running mode, successive `ready` pulses are (sampling + compensation + resolution) conversion-clock cycles apart. Example: 12 bits, 4 sampling cycles and no compensation give 16 conversion-clock cycles, which is one result per microsecond at a 16 MHz conversion clock. The next `samp_en` window starts in the cycle that `ready` is high.
- R8: A start request that arrives while a conversion is in progress is ignored.
- R9: Changes to `prescale`, `res_sel`, `samp_len` or `offcomp` during a conversion do not affect that conversion.
- R10: If `free_run` is low on the last data cycle, the sequencer returns to idle after that result. No further `samp_en`, `bit_stb` or `ready` follows until a new start request.
- R11: After reset, all strobes, `ready` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Asynchronous start request from software or an event |
| free_run | input | 1 | Restart automatically after each result |
| prescale | input | PW (3) | Conversion clock divide = 2^(1+prescale) |
| res_sel | input | 2 | 0/3: 12 bits, 1: 10 bits, 2: 8 bits |
| samp_len | input | SLW (6) | Sampling window minus one, in conversion-clock cycles |
| offcomp | input | 1 | Enable the offset-compensation phase and the fixed 4-cycle sampling window |
| cmp_in | input | 1 | Comparator decision for the current bit |
| samp_en | output | 1 | High during the sampling window |
| comp_en | output | 1 | High during the offset-compensation window |
| bit_stb | output | 1 | One-cycle strobe as each bit is decided |
| ready | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 12 | Right-aligned conversion code |

## Verification
The bench aims at the following corner cases:
- Synchronizer latency. A design with one flop too few or too many moves the start of the sampling window by a cycle. A design without the edge detector restarts while the request is held.
- Prescaler extremes. A wrong shift amount stretches or shrinks every bit cycle and the strobe spacing.
- Compensation override. A design that keeps using the programmed sample length with compensation on gives the wrong sampling count.
- Free-running boundary. A gap or overlap between the result and the next sampling window shows up as a wrong period. Disable handling is checked too: a design that stops at once, or never stops, gives a wrong number of results.
- Mid-conversion disturbances. A design that reads the live configuration changes its bit count. A design that accepts a start while busy produces an extra result.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int PW = 3,
  parameter int SLW = 6,
  parameter int OFF_SAMP = 4,
  parameter int COMP_CYC = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_req,
  input  logic           free_run,
  input  logic [PW-1:0]  prescale,
  input  logic [1:0]     res_sel,
  input  logic [SLW-1:0] samp_len,
  input  logic           offcomp,
  input  logic           cmp_in,
  output logic           samp_en,
  output logic           comp_en,
  output logic           bit_stb,
  output logic           ready,
  output logic [11:0]    result
);
  localparam int CW = 1 << PW;
  localparam int KW = SLW + 4;

  typedef enum logic [1:0] {IDLE, SAMP, COMP, DATA} st_t;

  st_t           st;
  logic          s1, s2, s3;
  logic [CW-1:0] pcnt, lim;
  logic [KW-1:0] ccnt, samp_last, last;
  logic [3:0]    bit_last;
  logic          comp_q;
  logic [10:0]   acc;
  logic          rise, tick, done, go;
  logic [PW:0]   shamt;
  logic [CW:0]   pw1;

  assign rise  = s2 & ~s3;
  assign tick  = (st != IDLE) && (pcnt == lim);
  assign done  = (st == DATA) && tick && (ccnt == last);
  assign go    = ((st == IDLE) && rise) || (done && free_run);
  assign shamt = {1'b0, prescale} + (PW+1)'(1);
  assign pw1   = (CW+1)'(1) << shamt;

  always_comb begin
    case (st)
      SAMP:    last = samp_last;
      COMP:    last = KW'(COMP_CYC - 1);
      default: last = KW'(bit_last);
    endcase
  end

  assign samp_en = (st == SAMP);
  assign comp_en = (st == COMP);
  assign bit_stb = (st == DATA) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      st <= IDLE; pcnt <= '0; ccnt <= '0; lim <= '0;
      samp_last <= '0; bit_last <= '0; comp_q <= 1'b0;
      acc <= '0; result <= '0; ready <= 1'b0;
    end else begin
      s1 <= start_req; s2 <= s1; s3 <= s2;
      ready <= 1'b0;
      if (st != IDLE) begin
        pcnt <= tick ? '0 : pcnt + CW'(1);
        if (tick) begin
          if (ccnt == last) begin
            ccnt <= '0;
            case (st)
              SAMP:    st <= comp_q ? COMP : DATA;
              COMP:    st <= DATA;
              default: st <= IDLE;
            endcase
          end else begin
            ccnt <= ccnt + KW'(1);
          end
          if (st == DATA) acc <= {acc[9:0], cmp_in};
        end
        if (done) begin
          result <= {acc, cmp_in};
          ready  <= 1'b1;
        end
      end
      if (go) begin
        st        <= SAMP;
        pcnt      <= '0;
        ccnt      <= '0;
        acc       <= '0;
        lim       <= CW'(pw1 - (CW+1)'(1));
        comp_q    <= offcomp;
        samp_last <= offcomp ? KW'(OFF_SAMP - 1) : KW'(samp_len);
        case (res_sel)
          2'd1:    bit_last <= 4'd9;
          2'd2:    bit_last <= 4'd7;
          default: bit_last <= 4'd11;
        endcase
      end
    end
  end
endmodule

module adc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        free_run,
  input logic        samp_en,
  input logic        comp_en,
  input logic        bit_stb,
  input logic        ready,
  input logic [11:0] result
);
  // R4
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(samp_en && comp_en));
  // R5
  stb_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (!samp_en && !comp_en));
  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> ready);
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(free_run)) |-> samp_en);
  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !$past(free_run)) |-> (!samp_en && !comp_en && !bit_stb));
endmodule

bind adc_seq adc_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .free_run(free_run), .samp_en(samp_en),
  .comp_en(comp_en), .bit_stb(bit_stb), .ready(ready), .result(result)
);

// File: tb/adc_seq_test.sv
`timescale 1ns/1ps
module adc_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, free_run = 1'b0, offcomp = 1'b0, cmp_in = 1'b0;
  logic [2:0] prescale = '0;
  logic [1:0] res_sel = '0;
  logic [5:0] samp_len = '0;
  logic samp_en, comp_en, bit_stb, ready;
  logic [11:0] result;
  logic [11:0] target = '0;

  always #2.5 clk = ~clk;

  adc_seq uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .free_run(free_run),
    .prescale(prescale), .res_sel(res_sel), .samp_len(samp_len),
    .offcomp(offcomp), .cmp_in(cmp_in), .samp_en(samp_en), .comp_en(comp_en),
    .bit_stb(bit_stb), .ready(ready), .result(result)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done_flag = 0;

  // reference model state
  bit q1 = 0, q2 = 0, q3 = 0, m_busy = 0, m_ready = 0;
  int el = 0, m_div = 2, m_ns = 1, m_nc = 0, m_nb = 12, m_tot = 0;
  logic [11:0] m_tgt = '0, m_result = '0;

  // observation counters
  int n_samp = 0, n_comp = 0, n_stb = 0, n_rdy = 0;
  int last_stb = 0, stb_gap = 0, last_rdy = 0, rdy_gap = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_launch();
    m_busy = 1; el = 0;
    m_div = 2 << prescale;
    m_ns = offcomp ? 4 : samp_len + 1;
    m_nc = offcomp ? 1 : 0;
    m_nb = (res_sel == 2'd1) ? 10 : (res_sel == 2'd2) ? 8 : 12;
    m_tot = (m_ns + m_nc + m_nb) * m_div;
    m_tgt = target;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done_flag) begin
      done_flag = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (!rst_n) begin
      m_busy = 0; el = 0; m_ready = 0; m_result = '0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      bit rise;
      rise = q2 && !q3;
      m_ready = 0;
      if (m_busy) begin
        if (el == m_tot - 1) begin
          m_result = m_tgt & 12'((1 << m_nb) - 1);
          m_ready = 1;
          if (free_run) do_launch();
          else m_busy = 0;
        end else el++;
      end else if (rise) do_launch();
      q3 = q2; q2 = q1; q1 = start_req;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int d0;
      d0 = (m_ns + m_nc) * m_div;
      chk("R3 samp_en", int'(samp_en), int'(m_busy && el < m_ns * m_div));
      chk("R4 comp_en", int'(comp_en), int'(m_busy && el >= m_ns * m_div && el < d0));
      chk("R5 bit_stb", int'(bit_stb), int'(m_busy && el >= d0 && (el % m_div) == m_div - 1));
      chk("R6 ready", int'(ready), int'(m_ready));
      chk("R6 result", int'(result), int'(m_result));
      n_samp += int'(samp_en); n_comp += int'(comp_en);
      if (bit_stb) begin n_stb++; stb_gap = cyc - last_stb; last_stb = cyc; end
      if (ready) begin n_rdy++; rdy_gap = cyc - last_rdy; last_rdy = cyc; end
      cmp_in = (m_busy && el >= d0) ? m_tgt[m_nb - 1 - (el - d0) / m_div] : 1'b0;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clr();
    n_samp = 0; n_comp = 0; n_stb = 0; n_rdy = 0;
  endtask

  task automatic cfg(int p, int r, int sl, bit oc, logic [11:0] tg);
    prescale = 3'(p); res_sel = 2'(r); samp_len = 6'(sl); offcomp = oc; target = tg;
  endtask

  task automatic kick(output int lat);
    lat = 0;
    start_req = 1'b1;
    do begin step(); lat++; end while (!samp_en && lat < 20);
    step();
    start_req = 1'b0;
  endtask

  task automatic wait_ready();
    int w = 0;
    while (!ready && w < 20000) begin step(); w++; end
    step();
  endtask

  int lat;

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    // R11
    chk("R11 reset outputs", int'({samp_en, comp_en, bit_stb, ready}), 0);
    chk("R11 reset result", int'(result), 0);

    cfg(0, 0, 0, 0, 12'hA5C); clr();
    kick(lat);
    chk("R1 start latency", lat, 3);
    wait_ready();
    chk("R5 12-bit strobes", n_stb, 12);
    chk("R6 12-bit code", int'(result), 'hA5C);
    chk("R3 one-cycle sample", n_samp, 2);
    repeat (20) step();
    chk("R1 held request no restart", n_rdy, 1);

    cfg(2, 1, 5, 0, 12'hFF1); clr();
    kick(lat);
    wait_ready();
    chk("R2 divide-8 strobe spacing", stb_gap, 8);
    chk("R3 six-cycle sample", n_samp, 48);
    chk("R5 10-bit strobes", n_stb, 10);
    chk("R6 10-bit code", int'(result), 'h3F1);

    cfg(1, 2, 10, 1, 12'h5A7); clr();
    kick(lat);
    wait_ready();
    chk("R4 fixed four-cycle sample", n_samp, 16);
    chk("R4 compensation length", n_comp, 4);
    chk("R5 8-bit strobes", n_stb, 8);
    chk("R6 8-bit code", int'(result), 'hA7);

    cfg(7, 2, 0, 0, 12'h0C3); clr();
    kick(lat);
    repeat (300) step();
    chk("R2 divide-256 no strobe yet", n_stb, 0);
    wait_ready();
    chk("R2 divide-256 strobe spacing", stb_gap, 256);

    cfg(0, 0, 3, 0, 12'h123); clr();
    kick(lat);
    repeat (5) step();
    start_req = 1'b1; repeat (3) step(); start_req = 1'b0;
    res_sel = 2'd2; samp_len = 6'd20; offcomp = 1'b1; prescale = 3'd3;
    wait_ready();
    repeat (80) step();
    chk("R8 busy start ignored", n_rdy, 1);
    chk("R9 live config ignored", n_stb, 12);
    chk("R9 sample length kept", n_samp, 8);

    cfg(0, 0, 3, 0, 12'h9E4); free_run = 1'b1; clr();
    kick(lat);
    wait_ready(); wait_ready(); wait_ready();
    chk("R7 free-run period 12-bit", rdy_gap, 32);
    cfg(1, 2, 0, 1, 12'h0B6);
    wait_ready(); wait_ready(); wait_ready();
    chk("R7 free-run period compensated", rdy_gap, 52);
    repeat (7) step();
    free_run = 1'b0;
    wait_ready();
    clr();
    repeat (120) step();
    chk("R10 stops after current", n_rdy + n_samp + n_stb, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule